// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a memory-mapped interval timer. A 32-bit counter counts down from a value that software programs. The count advances through an 8-bit prescaler that is fed by a peripheral clock enable. When the counter steps from one to zero, an event flag is raised. With the interrupt enabled, that flag drives a level interrupt output until software clears it.

Software reaches the timer through a simple synchronous register bus inside a 256-byte window. The bus has an address, a write enable, write data and combinational read data. Writing the reload register also loads the running counter at once. A mode bit chooses between two behaviours:

- **Single-shot:** the counter stops at zero.
- **Periodic:** the counter refills from the reload register on the step after it reaches zero.

Top module: `ivtimer`

## Requirements
- R1: Register decoding uses address bits 7:2; bits 1:0 are ignored.
  - Word 0 (0x00) reads the reload value.
  - Word 1 (0x04) reads the live counter.
  - Word 2 (0x08) reads control: bit 0 run, bit 1 periodic, bit 2 interrupt enable, bits 15:8 divider P, all other bits 0.
  - Word 3 (0x0C) reads the event flag in bit 0, with all other bits 0.
  - Every other offset reads 0 and ignores writes.
  - After reset, every register reads 0 and `irq` is 0.
- R2: A write to word 0 sets both the reload value and the counter to the written data at the same clock edge. This write takes priority over a count step in that cycle.
- R3: A write to word 1 sets only the counter and leaves the reload value unchanged.
- R4: While run is 1, the counter steps once every P+1 cycles in which `pclk_en` is 1. It never changes when run is 0 or when `pclk_en` is 0.
- R5: The prescaler phase restarts at zero on every write to word 0, and on any control write that changes run from 0 to 1. After such a restart, the next step comes P+1 qualified cycles later.
- R6: The event flag is set on the step that takes the counter from 1 to 0.
- R7: In single-shot mode (periodic = 0), a step at zero leaves the counter at 0 and does not set the flag again.
- R8: In periodic mode, a step at zero loads the counter from the reload value. A reload value of L therefore gives one event every L+1 steps.
- R9: Writing word 3 with bit 0 = 1 clears the flag; writing it with bit 0 = 0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq` equals the event flag ANDed with interrupt enable, as a level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_en | input | 1 | Peripheral clock tick qualifier |
| bus_addr | input | 8 | Byte address within the register window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can coincide in one cycle.

- **Flag set and software clear.** The bench counts the prescaled steps so that a write of 1 to the status word lands on the exact edge where the counter goes from 1 to 0. It then requires the flag to read 1 afterwards.
- **Reload write and count step.** The bench writes the reload register on the edge where a step was due. It then requires the counter to read the written value, not that value minus one, and the next step to follow one period later.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W = 32;

    // Word indices (byte offset / 4) within the register window
    localparam logic [5:0] WIDX_RELOAD = 6'd0;
    localparam logic [5:0] WIDX_COUNT  = 6'd1;
    localparam logic [5:0] WIDX_CTRL   = 6'd2;
    localparam logic [5:0] WIDX_STATUS = 6'd3;

    // Control word bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_PERIOD  = 1;
    localparam int CB_IE      = 2;
    localparam int CB_DIV_LSB = 8;

    typedef struct packed {
        logic run;
        logic periodic;
        logic ie;
    } ctrl_flags_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             step
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // >= keeps the period bounded if the divider is lowered mid-count
        step = tick_en && (st_q.phase >= div);
        if (restart) begin
            st_d.phase = '0;
        end else if (tick_en) begin
            st_d.phase = step ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_wr,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic             periodic,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload_val,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (reload_wr) begin
            st_d.cnt = wdata;
            st_d.rld = wdata;
        end else if (count_wr) begin
            st_d.cnt = wdata;
        end else if (step) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
                hit      = (st_q.cnt == CNT_W'(1));
            end else if (periodic) begin
                st_d.cnt = st_q.rld;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt        = st_q.cnt;
    assign reload_val = st_q.rld;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  reload_val,
    output logic              reload_wr,
    output logic              count_wr,
    output logic              restart,
    output logic              run,
    output logic              periodic,
    output logic [PRE_W-1:0]  div,
    output logic              flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        ctrl_flags_t      cf;
        logic [PRE_W-1:0] div;
        logic             flag;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic [WORD_W-1:0] widx;
    logic              ctrl_wr;
    logic              stat_clr;

    assign widx = bus_addr[ADDR_W-1:2];

    always_comb begin
        st_d      = st_q;
        reload_wr = bus_we && (widx == WORD_W'(WIDX_RELOAD));
        count_wr  = bus_we && (widx == WORD_W'(WIDX_COUNT));
        ctrl_wr   = bus_we && (widx == WORD_W'(WIDX_CTRL));
        stat_clr  = bus_we && (widx == WORD_W'(WIDX_STATUS)) && bus_wdata[0];
        restart   = reload_wr || (ctrl_wr && bus_wdata[CB_RUN] && !st_q.cf.run);

        if (ctrl_wr) begin
            st_d.cf.run      = bus_wdata[CB_RUN];
            st_d.cf.periodic = bus_wdata[CB_PERIOD];
            st_d.cf.ie       = bus_wdata[CB_IE];
            st_d.div         = bus_wdata[CB_DIV_LSB +: PRE_W];
        end
        // a set in the same cycle as a clear wins
        st_d.flag = hit || (st_q.flag && !stat_clr);
    end

    always_comb begin
        bus_rdata = '0;
        case (widx)
            WORD_W'(WIDX_RELOAD): bus_rdata = DATA_W'(reload_val);
            WORD_W'(WIDX_COUNT):  bus_rdata = DATA_W'(cnt);
            WORD_W'(WIDX_CTRL): begin
                bus_rdata[CB_RUN]              = st_q.cf.run;
                bus_rdata[CB_PERIOD]           = st_q.cf.periodic;
                bus_rdata[CB_IE]               = st_q.cf.ie;
                bus_rdata[CB_DIV_LSB +: PRE_W] = st_q.div;
            end
            WORD_W'(WIDX_STATUS): bus_rdata[0] = st_q.flag;
            default:              bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.cf.run;
    assign periodic = st_q.cf.periodic;
    assign div      = st_q.div;
    assign flag     = st_q.flag;
    assign irq      = st_q.flag && st_q.cf.ie;
endmodule

// File: rtl/ivtimer.sv
module ivtimer #(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic             reload_wr, count_wr, restart;
    logic             run, periodic, flag, step, hit;
    logic [PRE_W-1:0] div;
    logic [CNT_W-1:0] cnt_w, reload_w;

    ivt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .hit(hit), .cnt(cnt_w), .reload_val(reload_w),
        .reload_wr(reload_wr), .count_wr(count_wr), .restart(restart),
        .run(run), .periodic(periodic), .div(div), .flag(flag),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    ivt_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .tick_en(run && pclk_en),
        .restart(restart), .div(div), .step(step)
    );

    ivt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr), .count_wr(count_wr),
        .wdata(bus_wdata[CNT_W-1:0]), .step(step), .periodic(periodic),
        .cnt(cnt_w), .reload_val(reload_w), .hit(hit)
    );
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pclk_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload_val,
    input logic              flag,
    input logic              periodic
);
    logic [ADDR_W-3:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    assert_reload_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && widx == 0) |=> (cnt == $past(bus_wdata[CNT_W-1:0]) &&
                                   reload_val == $past(bus_wdata[CNT_W-1:0])));

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pclk_en && !bus_we) |=> $stable(cnt));

    assert_flag_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == '0));

    assert_oneshot_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !periodic && !bus_we) |=> (cnt == '0));

    assert_write0_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && bus_we && widx == 3 && !bus_wdata[0]) |=> flag);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_ctrl_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == 2) |-> (bus_rdata[31:16] == '0 && bus_rdata[7:3] == '0));
endmodule

bind ivtimer ivtimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cnt(cnt_w), .reload_val(reload_w), .flag(flag), .periodic(periodic)
);

// File: tb/ivtimer_tb.sv
`timescale 1ns/1ps
module ivtimer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_RLD = 8'h00, A_CNT = 8'h04, A_CTL = 8'h08, A_STS = 8'h0C;

    always #5 clk = ~clk;

    ivtimer dut_i (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {write, addr, data-or-expected, requirement number}; pclk_en held low
    localparam int NV = 17;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'h0000_1234, 4'd2},  // R2 reload write
        {1'b0, 8'h00, 32'h0000_1234, 4'd2},
        {1'b0, 8'h04, 32'h0000_1234, 4'd2},  // R2 counter loaded too
        {1'b0, 8'h02, 32'h0000_1234, 4'd1},  // R1 low address bits ignored
        {1'b1, 8'h08, 32'hFFFF_FFFF, 4'd1},
        {1'b0, 8'h08, 32'h0000_FF07, 4'd1},  // R1 only defined control bits kept
        {1'b0, 8'h04, 32'h0000_1234, 4'd4},  // R4 run=1 but no tick: no change
        {1'b0, 8'h0C, 32'h0000_0000, 4'd1},
        {1'b1, 8'h04, 32'h0000_0055, 4'd3},  // R3 counter-only write
        {1'b0, 8'h04, 32'h0000_0055, 4'd3},
        {1'b0, 8'h00, 32'h0000_1234, 4'd3},
        {1'b1, 8'h40, 32'hDEAD_BEEF, 4'd1},
        {1'b0, 8'h40, 32'h0000_0000, 4'd1},
        {1'b0, 8'hFC, 32'h0000_0000, 4'd1},
        {1'b0, 8'h10, 32'h0000_0000, 4'd1},
        {1'b1, 8'h08, 32'h0000_0000, 4'd1},
        {1'b0, 8'h08, 32'h0000_0000, 4'd1}
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_err++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        n_chk++;
        if (irq !== exp) begin
            n_err++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        wait_n(3);
        // R1 reset state
        chk_reg(A_RLD, 0, "R1 reset reload");
        chk_reg(A_CNT, 0, "R1 reset count");
        chk_reg(A_CTL, 0, "R1 reset ctrl");
        chk_reg(A_STS, 0, "R1 reset status");
        chk_irq(1'b0, "R10 reset irq");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) wr(VEC[i][43:36], VEC[i][35:4]);
            else chk_reg(VEC[i][43:36], VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // One-shot countdown, P=0 (R4 R6 R7 R10 R9)
        pclk_en = 1'b1;
        wr(A_RLD, 3);
        wr(A_CTL, 32'h1);
        wait_n(2);
        chk_reg(A_CNT, 1, "R4 count step");
        chk_reg(A_STS, 0, "R6 no flag before zero");
        wait_n(1);
        chk_reg(A_CNT, 0, "R4 reached zero");
        chk_reg(A_STS, 1, "R6 flag at zero");
        chk_irq(1'b0, "R10 masked");
        wr(A_CTL, 32'h5);
        chk_irq(1'b1, "R10 enabled level");
        wr(A_STS, 0);
        chk_reg(A_STS, 1, "R9 write 0 no effect");
        chk_irq(1'b1, "R10 level held");
        wr(A_STS, 1);
        chk_reg(A_STS, 0, "R9 write 1 clears");
        chk_irq(1'b0, "R10 drops with flag");
        wait_n(4);
        chk_reg(A_CNT, 0, "R7 stays at zero");
        chk_reg(A_STS, 0, "R7 no second event");

        // Periodic mode, P=1 (R8 R4)
        wr(A_CTL, 0);
        wr(A_RLD, 2);
        wr(A_CTL, 32'h0000_0103);
        wait_n(3);
        chk_reg(A_CNT, 1, "R4 divide by P+1");
        wait_n(1);
        chk_reg(A_CNT, 0, "R4 periodic zero");
        chk_reg(A_STS, 1, "R6 periodic flag");
        wait_n(1);
        chk_reg(A_CNT, 0, "R8 holds zero for one period");
        wait_n(1);
        chk_reg(A_CNT, 2, "R8 reload from register");
        wr(A_STS, 1);
        wait_n(1);
        chk_reg(A_CNT, 1, "R8 counts after reload");

        // Tick qualifier (R4)
        wr(A_CTL, 0);
        wr(A_STS, 1);
        pclk_en = 1'b0;
        wr(A_RLD, 10);
        wr(A_CTL, 32'h1);
        wait_n(5);
        chk_reg(A_CNT, 10, "R4 no step without tick");
        pclk_en = 1'b1;
        wait_n(3);
        chk_reg(A_CNT, 7, "R4 steps with tick");

        // Prescaler restart on reload write, P=3 (R5)
        wr(A_CTL, 0);
        wr(A_RLD, 100);
        wr(A_CTL, 32'h0000_0301);
        wait_n(6);
        chk_reg(A_CNT, 99, "R5 first step after P+1");
        wr(A_RLD, 50);
        chk_reg(A_CNT, 50, "R2 reload write");
        wait_n(1);
        chk_reg(A_CNT, 50, "R5 phase restarted");
        wait_n(3);
        chk_reg(A_CNT, 49, "R5 step P+1 after restart");

        // Reload write against a due step, P=0 (R2)
        wr(A_CTL, 0);
        wr(A_RLD, 20);
        wr(A_CTL, 32'h1);
        wait_n(1);
        chk_reg(A_CNT, 19, "R4 step");
        wr(A_RLD, 50);
        chk_reg(A_CNT, 50, "R2 write beats step");
        wait_n(1);
        chk_reg(A_CNT, 49, "R2 next step");

        // Set and clear in one cycle (R9)
        wr(A_CTL, 0);
        wr(A_STS, 1);
        wr(A_RLD, 1);
        wr(A_CTL, 32'h1);
        wait_n(1);
        chk_reg(A_STS, 1, "R6 flag from 1");
        wr(A_RLD, 2);
        wait_n(1);
        wr(A_STS, 1);
        chk_reg(A_CNT, 0, "R6 zero on collision edge");
        chk_reg(A_STS, 1, "R9 set wins over clear");
        wr(A_STS, 1);
        chk_reg(A_STS, 0, "R9 clear after collision");

        finish_run();
    end
endmodule